// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder for a Byte-Wide Nonvolatile Memory

This block sits beside the write port of a parallel byte-wide nonvolatile memory. It inspects every bus write cycle, each carrying an address and a data byte, and recognises the key-coded command sequences that unlock the memory's internal operations. It covers protected page write, protection removal, whole-array erase, and entry to and exit from identification mode. Each decoded command leaves the block as a one-cycle pulse. The block also holds a global software write-protect flag, which is a level output.

Write cycles that do not belong to a command are passed to a downstream page-load controller as accepted data writes. The exceptions are writes made while protection is set outside an open page window. Such a write is refused, and the block then ignores the bus for a parameterised number of microsecond ticks. In identification mode a small read port returns two code bytes, both set by parameters.

The sequence tracker is a six-state machine:
- SQ_IDLE: waiting for the first key.
- SQ_KEY1: the first key has been seen.
- SQ_KEY2: both keys have been seen, and the opcode is next.
- SQ_EXT: the extended opcode 80h has been seen.
- SQ_EXT_KEY1: the repeated first key has been seen.
- SQ_EXT_KEY2: the repeated second key has been seen, and the final opcode is next.

Its transitions are:
- *advance*: the expected key or opcode arrived.
- *issue*: a final opcode matched, and the machine returns to SQ_IDLE with a command.
- *restart*: a cycle did not match, but it is itself a first key, so the machine goes to SQ_KEY1.
- *abort*: a cycle did not match and is no key, so the machine goes to SQ_IDLE and treats the cycle as data.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset, prot_on, page_win, id_mode, lock_busy and wr_accept are 0, and no command pulse is active. Protection starts disabled.
- R2: The cycles AAh@5555h, 55h@2AAAh and A0h@5555h produce a one-cycle cmd_prot_pg pulse, set prot_on to 1 and open page_win.
- R3: While page_win is 1, every write is accepted as data and is not decoded as a command, even a key byte. A page_done pulse closes the window, and prot_on stays 1.
- R4: The cycles AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 20h@5555h produce cmd_unprot and clear prot_on.
- R5: The same six-cycle prefix ending in 10h@5555h produces cmd_erase and leaves prot_on unchanged.
- R6: Identification mode is entered by the three-cycle opcode 90h or the six-cycle final opcode 60h, each with a cmd_id_enter pulse. It is left by the three-cycle opcode F0h, with a cmd_id_exit pulse. id_mode shows the mode.
- R7: In identification mode, a read at rd_addr 0 gives id_valid=1 and id_rdata=MFR_CODE, and rd_addr 1 gives DEV_CODE. Any other address, or not being in the mode, gives id_valid=0 and id_rdata=0. Only rd_addr bits 14..0 are compared.
- R8: Address bit 15 and above are ignored in every command comparison. Only bits 14..0 are matched.
- R9: A cycle that breaks a sequence returns the tracker to idle and is re-evaluated as a possible first key. Key cycles that belong to a sequence are never accepted as data, and an abort cycle is handled as a data write.
- R10: With protection disabled, a non-command write is accepted. wr_accept pulses, and wr_acc_addr and wr_acc_data hold that cycle's address and data.
- R11: With protection enabled and no window open, a non-command write is refused. lock_busy rises and stays high for LOCK_TICKS ticks of us_tick. While busy, every write is ignored: it is neither accepted nor decoded.
- R12: Every output responds in the clock cycle after the edge that samples the write, and each command pulse lasts exactly one cycle. At most one command pulse is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power loss) |
| wr_valid | input | 1 | A bus write cycle is present |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| us_tick | input | 1 | One-cycle microsecond tick |
| page_done | input | 1 | Downstream page load finished, closes the window |
| rd_addr | input | 16 | Read address for identification codes |
| prot_on | output | 1 | Global software write-protect flag |
| page_win | output | 1 | A protected page-write window is open |
| cmd_prot_pg | output | 1 | Pulse: protect and open a page write |
| cmd_unprot | output | 1 | Pulse: protection removed |
| cmd_erase | output | 1 | Pulse: whole-array erase |
| cmd_id_enter | output | 1 | Pulse: identification mode entered |
| cmd_id_exit | output | 1 | Pulse: identification mode left |
| wr_accept | output | 1 | Pulse: a data write is passed downstream |
| wr_acc_addr | output | 16 | Address of the accepted write |
| wr_acc_data | output | 8 | Data of the accepted write |
| lock_busy | output | 1 | Refusal lockout is running |
| id_mode | output | 1 | Identification mode is active |
| id_valid | output | 1 | rd_addr selects an identification code |
| id_rdata | output | 8 | Identification code byte |

## Verification
The bench aims at the restart rule. In one case a repeated first key is followed by the rest of a sequence, and a tracker that drops to idle without re-evaluating the breaking cycle would lose that command. Another case breaks the opcode cycle with a foreign byte. A design that swallowed such a byte would then fail to pass it on as data.

Further cases send key bytes inside an open page window, where a decoder that stayed armed would fire a command. Other cases set address bit 15 on every key, which a full-width compare would reject. A command is also sent during the refusal lockout, and a leaky lockout would let it through. Long random runs weighted toward key and opcode bytes are compared each cycle against a reference model written from the requirements.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] ADR_KEY_A = 15'h5555;
    localparam logic [CMP_W-1:0] ADR_KEY_B = 15'h2AAA;

    localparam logic [7:0] BYTE_KEY_A = 8'hAA;
    localparam logic [7:0] BYTE_KEY_B = 8'h55;
    localparam logic [7:0] OP_PROT    = 8'hA0;
    localparam logic [7:0] OP_EXT     = 8'h80;
    localparam logic [7:0] OP_ID_ON   = 8'h90;
    localparam logic [7:0] OP_ID_OFF  = 8'hF0;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_UNPROT  = 8'h20;
    localparam logic [7:0] OP_ID_ALT  = 8'h60;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_EXT,
        SQ_EXT_KEY1,
        SQ_EXT_KEY2
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_DATA,
        CMD_PROT_PG,
        CMD_UNPROT,
        CMD_ERASE,
        CMD_ID_ON,
        CMD_ID_OFF
    } cmd_t;

endpackage

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output cmd_t              cmd,
    output seq_state_t        state
);

    logic [CMP_W-1:0] low_addr;
    logic             is_key1;
    logic             is_key2;
    logic             at_a;
    seq_state_t       nxt;

    assign low_addr = addr[CMP_W-1:0];
    assign at_a     = (low_addr == ADR_KEY_A);
    assign is_key1  = at_a && (data == BYTE_KEY_A);
    assign is_key2  = (low_addr == ADR_KEY_B) && (data == BYTE_KEY_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else if (en) begin
            state <= nxt;
        end
    end

    always_comb begin
        // restart / abort by default: the breaking cycle is re-evaluated
        nxt = is_key1 ? SQ_KEY1 : SQ_IDLE;
        cmd = is_key1 ? CMD_NONE : CMD_DATA;
        unique case (state)
            SQ_IDLE: begin
            end
            SQ_KEY1: begin
                if (is_key2) begin
                    nxt = SQ_KEY2;
                    cmd = CMD_NONE;
                end
            end
            SQ_KEY2: begin
                if (at_a) begin
                    case (data)
                        OP_PROT:   begin nxt = SQ_IDLE; cmd = CMD_PROT_PG; end
                        OP_ID_ON:  begin nxt = SQ_IDLE; cmd = CMD_ID_ON;   end
                        OP_ID_OFF: begin nxt = SQ_IDLE; cmd = CMD_ID_OFF;  end
                        OP_EXT:    begin nxt = SQ_EXT;  cmd = CMD_NONE;    end
                        default:   begin end
                    endcase
                end
            end
            SQ_EXT: begin
                if (is_key1) begin
                    nxt = SQ_EXT_KEY1;
                    cmd = CMD_NONE;
                end
            end
            SQ_EXT_KEY1: begin
                if (is_key2) begin
                    nxt = SQ_EXT_KEY2;
                    cmd = CMD_NONE;
                end
            end
            SQ_EXT_KEY2: begin
                if (at_a) begin
                    case (data)
                        OP_ERASE:  begin nxt = SQ_IDLE; cmd = CMD_ERASE;  end
                        OP_UNPROT: begin nxt = SQ_IDLE; cmd = CMD_UNPROT; end
                        OP_ID_ALT: begin nxt = SQ_IDLE; cmd = CMD_ID_ON;  end
                        default:   begin end
                    endcase
                end
            end
            default: begin
                nxt = SQ_IDLE;
            end
        endcase
        if (!en) begin
            nxt = state;
            cmd = CMD_NONE;
        end
    end

    // the opcode state is reached only from the second-key state
    assert_key_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_KEY2 && $past(state) != SQ_KEY2) |-> ($past(state) == SQ_KEY1));

    // the six-cycle opcode state is reached only through its repeated keys
    assert_ext_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_EXT_KEY2 && $past(state) != SQ_EXT_KEY2) |-> ($past(state) == SQ_EXT_KEY1));

    // a disabled tracker holds its place
    assert_hold_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state));

endmodule

// File: rtl/unlock_lockout.sv
module unlock_lockout #(
    parameter int LOCK_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy
);

    localparam int CNT_W = $clog2(LOCK_TICKS + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(LOCK_TICKS);
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    assert_lock_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !start) |=> $stable(cnt));

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import unlock_pkg::*;
#(
    parameter int         ADDR_W     = 16,
    parameter logic [7:0] MFR_CODE   = 8'hC3,
    parameter logic [7:0] DEV_CODE   = 8'h2E,
    parameter int         LOCK_TICKS = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              us_tick,
    input  logic              page_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_on,
    output logic              page_win,
    output logic              cmd_prot_pg,
    output logic              cmd_unprot,
    output logic              cmd_erase,
    output logic              cmd_id_enter,
    output logic              cmd_id_exit,
    output logic              wr_accept,
    output logic [ADDR_W-1:0] wr_acc_addr,
    output logic [7:0]        wr_acc_data,
    output logic              lock_busy,
    output logic              id_mode,
    output logic              id_valid,
    output logic [7:0]        id_rdata
);

    logic       cyc;
    logic       fsm_en;
    logic       lock_start;
    logic       take_data;
    cmd_t       cmd;
    seq_state_t seq_state;

    assign cyc        = wr_valid && !lock_busy;
    assign fsm_en     = cyc && !page_win;
    assign take_data  = (cyc && page_win) || (cmd == CMD_DATA && !prot_on);
    assign lock_start = (cmd == CMD_DATA) && prot_on;

    unlock_seq_fsm #(.ADDR_W(ADDR_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fsm_en),
        .addr  (wr_addr),
        .data  (wr_data),
        .cmd   (cmd),
        .state (seq_state)
    );

    unlock_lockout #(.LOCK_TICKS(LOCK_TICKS)) lock_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lock_start),
        .tick  (us_tick),
        .busy  (lock_busy)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_on      <= 1'b0;
            page_win     <= 1'b0;
            id_mode      <= 1'b0;
            cmd_prot_pg  <= 1'b0;
            cmd_unprot   <= 1'b0;
            cmd_erase    <= 1'b0;
            cmd_id_enter <= 1'b0;
            cmd_id_exit  <= 1'b0;
            wr_accept    <= 1'b0;
            wr_acc_addr  <= '0;
            wr_acc_data  <= '0;
        end else begin
            cmd_prot_pg  <= (cmd == CMD_PROT_PG);
            cmd_unprot   <= (cmd == CMD_UNPROT);
            cmd_erase    <= (cmd == CMD_ERASE);
            cmd_id_enter <= (cmd == CMD_ID_ON);
            cmd_id_exit  <= (cmd == CMD_ID_OFF);
            wr_accept    <= take_data;
            if (take_data) begin
                wr_acc_addr <= wr_addr;
                wr_acc_data <= wr_data;
            end
            if (page_done) begin
                page_win <= 1'b0;
            end
            unique case (cmd)
                CMD_PROT_PG: begin prot_on <= 1'b1; page_win <= 1'b1; end
                CMD_UNPROT:  prot_on <= 1'b0;
                CMD_ID_ON:   id_mode <= 1'b1;
                CMD_ID_OFF:  id_mode <= 1'b0;
                default:     begin end
            endcase
        end
    end

    always_comb begin
        id_valid = id_mode && (rd_addr[CMP_W-1:1] == '0);
        id_rdata = 8'h00;
        if (id_valid) begin
            id_rdata = rd_addr[0] ? DEV_CODE : MFR_CODE;
        end
    end

    assert_prot_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> ($past(cmd) == CMD_PROT_PG));

    assert_prot_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> ($past(cmd) == CMD_UNPROT));

    assert_win_protected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        page_win |-> prot_on);

    assert_pulse_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_prot_pg, cmd_unprot, cmd_erase, cmd_id_enter, cmd_id_exit}));

    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_busy |=> (!wr_accept && !cmd_prot_pg && !cmd_unprot && !cmd_erase
                       && !cmd_id_enter && !cmd_id_exit));

endmodule

// File: tb/unlock_cmd_decoder_tb_top.sv
module unlock_cmd_decoder_tb_top;

    localparam int         LOCK = 8;
    localparam logic [7:0] MFR  = 8'hC3;
    localparam logic [7:0] DEV  = 8'h2E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        us_tick = 1'b0;
    logic        page_done = 1'b0;
    logic [15:0] rd_addr = '0;
    logic        prot_on, page_win, cmd_prot_pg, cmd_unprot, cmd_erase;
    logic        cmd_id_enter, cmd_id_exit, wr_accept, lock_busy, id_mode, id_valid;
    logic [15:0] wr_acc_addr;
    logic [7:0]  wr_acc_data, id_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(16), .MFR_CODE(MFR), .DEV_CODE(DEV), .LOCK_TICKS(LOCK)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .us_tick(us_tick), .page_done(page_done), .rd_addr(rd_addr),
        .prot_on(prot_on), .page_win(page_win), .cmd_prot_pg(cmd_prot_pg),
        .cmd_unprot(cmd_unprot), .cmd_erase(cmd_erase), .cmd_id_enter(cmd_id_enter),
        .cmd_id_exit(cmd_id_exit), .wr_accept(wr_accept), .wr_acc_addr(wr_acc_addr),
        .wr_acc_data(wr_acc_data), .lock_busy(lock_busy), .id_mode(id_mode),
        .id_valid(id_valid), .id_rdata(id_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int         m_st, m_lock;
    bit         m_prot, m_win, m_id, e_acc;
    bit [4:0]   e_pulse;   // {prot_pg, unprot, erase, id_enter, id_exit}
    bit [15:0]  e_aaddr;
    bit [7:0]   e_adata;

    // codes: 0 none, 1 data, 2 protect, 3 unprotect, 4 erase, 5 id on, 6 id off
    function automatic int decode(input int st, input logic [15:0] a, input logic [7:0] d,
                                  output int nst);
        bit k1, k2, at;
        at = (a[14:0] == 15'h5555);
        k1 = at && d == 8'hAA;
        k2 = (a[14:0] == 15'h2AAA) && d == 8'h55;
        if (st == 1 && k2) begin nst = 2; return 0; end
        if (st == 3 && k1) begin nst = 4; return 0; end
        if (st == 4 && k2) begin nst = 5; return 0; end
        if (st == 2 && at) begin
            nst = 0;
            if (d == 8'hA0) return 2;
            if (d == 8'h90) return 5;
            if (d == 8'hF0) return 6;
            if (d == 8'h80) begin nst = 3; return 0; end
        end
        if (st == 5 && at) begin
            nst = 0;
            if (d == 8'h10) return 4;
            if (d == 8'h20) return 3;
            if (d == 8'h60) return 5;
        end
        nst = k1 ? 1 : 0;
        return k1 ? 0 : 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_lock = 0; m_prot = 0; m_win = 0; m_id = 0;
            e_acc = 0; e_pulse = 0; e_aaddr = 0; e_adata = 0;
        end else begin
            bit cyc, w;
            int code, nst;
            cyc = wr_valid && m_lock == 0;
            w = m_win;
            e_pulse = 0;
            e_acc = 0;
            if (us_tick && m_lock > 0) m_lock--;
            if (page_done) m_win = 0;
            if (cyc && w) begin
                e_acc = 1;
            end else if (cyc) begin
                code = decode(m_st, wr_addr, wr_data, nst);
                m_st = nst;
                case (code)
                    1: if (!m_prot) e_acc = 1; else m_lock = LOCK;
                    2: begin m_prot = 1; m_win = 1; e_pulse[4] = 1; end
                    3: begin m_prot = 0; e_pulse[3] = 1; end
                    4: e_pulse[2] = 1;
                    5: begin m_id = 1; e_pulse[1] = 1; end
                    6: begin m_id = 0; e_pulse[0] = 1; end
                    default: ;
                endcase
            end
            if (e_acc) begin e_aaddr = wr_addr; e_adata = wr_data; end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit ev;
            ev = m_id && rd_addr[14:1] == 0;
            check("R2 prot_on", prot_on, m_prot);
            check("R3 page_win", page_win, m_win);
            check("R12 pulses", {cmd_prot_pg, cmd_unprot, cmd_erase, cmd_id_enter, cmd_id_exit}, e_pulse);
            check("R10 wr_accept", wr_accept, e_acc);
            if (e_acc) check("R10 accepted addr/data", {wr_acc_addr, wr_acc_data}, {e_aaddr, e_adata});
            check("R11 lock_busy", lock_busy, m_lock != 0);
            check("R6 id_mode", id_mode, m_id);
            check("R7 id_valid", id_valid, ev);
            check("R7 id_rdata", id_rdata, ev ? (rd_addr[0] ? DEV : MFR) : 8'h00);
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        forever begin
            @(posedge clk);
            #1 us_tick = ~us_tick;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic key2(input logic [7:0] op);
        wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, op);
    endtask

    task automatic key6(input logic [7:0] op);
        key2(8'h80); key2(op);
    endtask

    task automatic wait_unlock();
        while (lock_busy) begin @(posedge clk); #1; end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R1 prot_on at reset", prot_on, 0);
        check("R1 lock_busy at reset", lock_busy, 0);
        check("R1 id_mode at reset", id_mode, 0);
        check("R1 page_win at reset", page_win, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 no pulse after reset", {cmd_prot_pg, cmd_unprot, cmd_erase, cmd_id_enter, cmd_id_exit, wr_accept}, 0);

        // R2: protect with page write
        key2(8'hA0);
        check("R2 prot pulse", cmd_prot_pg, 1);
        check("R2 prot_on", prot_on, 1);
        check("R2 window open", page_win, 1);
        @(posedge clk); #1;
        check("R12 pulse one cycle", cmd_prot_pg, 0);

        // R3: window writes are data, keys included
        wr(16'h0100, 8'h12);
        check("R3 window write accepted", {wr_accept, wr_acc_addr, wr_acc_data}, {1'b1, 16'h0100, 8'h12});
        wr(16'h5555, 8'hAA);
        check("R3 key in window is data", {wr_accept, cmd_prot_pg}, 2'b10);
        @(posedge clk); #1 page_done = 1'b1;
        @(posedge clk); #1 page_done = 1'b0;
        check("R3 window closed", page_win, 0);
        check("R3 protection kept", prot_on, 1);

        // R11: refused write and lockout
        wr(16'h0200, 8'h34);
        check("R11 refused write", wr_accept, 0);
        check("R11 lockout raised", lock_busy, 1);
        key2(8'h90);
        check("R11 command ignored while busy", id_mode, 0);
        wait_unlock();
        check("R11 lockout ends", lock_busy, 0);

        // R8 + R6: id entry with bit 15 set on every cycle
        wr(16'hD555, 8'hAA); wr(16'hAAAA, 8'h55); wr(16'hD555, 8'h90);
        check("R8 high address bit ignored", cmd_id_enter, 1);
        check("R6 id mode on", id_mode, 1);
        rd_addr = 16'h0000; #1;
        check("R7 manufacturer code", {id_valid, id_rdata}, {1'b1, MFR});
        rd_addr = 16'h0001; #1;
        check("R7 device code", {id_valid, id_rdata}, {1'b1, DEV});
        rd_addr = 16'h0002; #1;
        check("R7 other address", {id_valid, id_rdata}, 9'h000);
        key2(8'hF0);
        check("R6 id exit", {cmd_id_exit, id_mode}, 2'b10);

        // R9 + R4: repeated first key restarts, then unprotect
        wr(16'h5555, 8'hAA);
        key6(8'h20);
        check("R4 unprotect pulse", cmd_unprot, 1);
        check("R4 prot cleared", prot_on, 0);

        // R5: erase keeps protection state
        key6(8'h10);
        check("R5 erase pulse", cmd_erase, 1);
        check("R5 prot unchanged", prot_on, 0);

        // R10: plain data accepted when unprotected
        wr(16'h0123, 8'h5A);
        check("R10 data accepted", {wr_accept, wr_acc_addr, wr_acc_data}, {1'b1, 16'h0123, 8'h5A});

        // R9: broken opcode cycle becomes data, keys not passed on
        wr(16'h5555, 8'hAA);
        check("R9 key not data", wr_accept, 0);
        wr(16'h2AAA, 8'h55);
        wr(16'h5555, 8'h77);
        check("R9 abort cycle is data", {wr_accept, wr_acc_data}, {1'b1, 8'h77});

        // R6: alternate six-cycle id entry
        key6(8'h60);
        check("R6 alternate id entry", {cmd_id_enter, id_mode}, 2'b11);
        key2(8'hF0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            wr_valid  = ($urandom_range(3) != 0);
            case ($urandom_range(3))
                0: wr_addr = 16'h5555;
                1: wr_addr = 16'h2AAA;
                2: wr_addr = 16'hD555 ^ {1'b0, 15'($urandom_range(1)) << 15};
                default: wr_addr = 16'($urandom);
            endcase
            case ($urandom_range(9))
                0, 1: wr_data = 8'hAA;
                2, 3: wr_data = 8'h55;
                4: wr_data = 8'hA0;
                5: wr_data = 8'h80;
                6: wr_data = ($urandom_range(1) != 0) ? 8'h90 : 8'hF0;
                7: wr_data = ($urandom_range(1) != 0) ? 8'h20 : 8'h10;
                8: wr_data = 8'h60;
                default: wr_data = 8'($urandom);
            endcase
            page_done = ($urandom_range(7) == 0);
            rd_addr   = ($urandom_range(1) != 0) ? 16'($urandom_range(2)) : 16'($urandom);
        end
        @(posedge clk); #1;
        wr_valid = 1'b0; page_done = 1'b0;
        repeat (3) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule